// File: doc/BRIEF.md
# Clustered Thread Priority Request Arbiter

This block chooses one entry per cycle from a queue of pending memory requests for a shared DRAM controller. Each queue slot carries a valid bit, the issuing core number, a row-hit flag supplied by the bank logic, and an age value in which larger means older. The arbiter does not track bank state or DRAM timing. It only ranks the pending entries and reports which slot should issue next.

A per-core load figure from an external profiler is sampled once per interval. At that point the cores are ordered from lightest to heaviest. Starting from the lightest, cores join a light (latency-sensitive) group as long as the running sum of their load stays within a configurable fraction of the total load. All remaining cores form the heavy (bandwidth-sensitive) group. Inside the light group, a lower load gives higher priority. Inside the heavy group, priority follows a permutation that is reshuffled on a fixed period. A Fisher–Yates pass driven by an LFSR builds the new permutation one swap per cycle, and the new order takes effect only when the pass ends. Row hits and then age break any remaining ties.

The grant index and its valid flag are registered. They reflect the queue contents seen at the previous clock edge.

Top module: `clustered_req_arbiter`

## Requirements
- R1: Any valid entry whose core is in the light group wins over every valid entry whose core is in the heavy group, whatever their row-hit flags and ages.
- R2: Between two light-group cores, the one with the smaller sampled load wins. When the loads are equal, the smaller core number wins.
- R3: Group membership is decided as follows. Cores are ordered by (load, core number), ascending. A core is light when the sum of the loads up to and including itself, multiplied by FRAC_DEN, is not greater than the total load multiplied by FRAC_NUM. With a total load of zero, every core is light.
- R4: Heavy-group priority follows a permutation of the cores. The permutation is rebuilt every SHUFFLE_CYC cycles by an LFSR-driven Fisher–Yates pass at one swap per cycle and is replaced only when the pass completes. Over successive periods, either of two heavy cores can be the winner.
- R5: When two entries have equal core priority, the one with its row-hit flag set wins over a row miss.
- R6: When core priority and the row-hit flag are equal, the entry with the larger age value wins.
- R7: When all of the above are equal, the lowest queue slot wins.
- R8: In the cycle after an edge at which no slot is valid, grant_valid is low and grant_idx keeps its previous value. Following reset, grant_valid is 0 and grant_idx is 0. A grant appears one clock after the edge that sampled the request.
- R9: Group membership and light ranks are recomputed only at an interval boundary, which occurs every INTERVAL_CYC cycles counted from reset release. A load change in the middle of an interval has no effect until the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | Q_DEPTH | One valid bit per queue slot |
| req_core | input | Q_DEPTH*CORE_W | Core number of slot e, at bits [e*CORE_W +: CORE_W] |
| req_row_hit | input | Q_DEPTH | Row-hit flag per slot (1 = hit) |
| req_age | input | Q_DEPTH*AGE_W | Age of slot e, at bits [e*AGE_W +: AGE_W]; larger is older |
| core_load | input | N_CORES*LOAD_W | Profiled load of core c, at bits [c*LOAD_W +: LOAD_W] |
| grant_valid | output | 1 | A grant was chosen from the previous cycle's queue |
| grant_idx | output | IDX_W | Queue slot that was granted |

## Verification
The bench builds the block with four cores, four queue slots, 8-bit loads and 4-bit ages. It sets a 32-cycle interval and a 16-cycle shuffle period, so a few hundred cycles cover many membership recomputations and dozens of completed permutations. With a fraction of 1/6, hand-chosen load sets produce a clean split between two light and two heavy cores, a three-light split with tied loads, and an all-light case at zero total. Because the interval is short, the bench can change loads in mid-interval and then observe the change take effect at the following boundary.

// File: rtl/cra_pkg.sv
package cra_pkg;

  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_RUN  = 1'b1
  } sh_state_e;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cra_cluster_unit.sv
module cra_cluster_unit
  import cra_pkg::*;
#(
  parameter int unsigned N_CORES      = 4,
  parameter int unsigned LOAD_W       = 16,
  parameter int unsigned INTERVAL_CYC = 10000,
  parameter int unsigned FRAC_NUM     = 1,
  parameter int unsigned FRAC_DEN     = 6,
  localparam int unsigned CORE_W      = idx_w(N_CORES)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_CORES*LOAD_W-1:0]   core_load,
  output logic                        boundary,
  output logic [N_CORES-1:0]          light_mask,
  output logic [N_CORES*CORE_W-1:0]   light_rank
);

  localparam int unsigned SUM_W  = LOAD_W + CORE_W + 1;
  localparam int unsigned PROD_W = SUM_W + 16;
  localparam int unsigned CNT_W  = $clog2(INTERVAL_CYC + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [LOAD_W-1:0] ld      [N_CORES];
  logic [SUM_W-1:0]  prefix  [N_CORES];
  logic [CORE_W-1:0] rank    [N_CORES];
  logic [SUM_W-1:0]  total;
  logic [N_CORES-1:0] light_next;

  assign boundary = (cnt_q == CNT_W'(INTERVAL_CYC - 1));

  // Rank each core by (load, core number) and form lightest-first prefix sums.
  always_comb begin
    total = '0;
    for (int i = 0; i < N_CORES; i++) begin
      ld[i] = core_load[i*LOAD_W +: LOAD_W];
      total = total + SUM_W'(ld[i]);
    end
    for (int i = 0; i < N_CORES; i++) begin
      prefix[i] = '0;
      rank[i]   = '0;
      for (int j = 0; j < N_CORES; j++) begin
        logic ahead;
        ahead = (ld[j] < ld[i]) || ((ld[j] == ld[i]) && (j < i));
        if (ahead) rank[i] = rank[i] + CORE_W'(1);
        if (ahead || (j == i)) prefix[i] = prefix[i] + SUM_W'(ld[j]);
      end
      light_next[i] = (PROD_W'(prefix[i]) * PROD_W'(FRAC_DEN)) <=
                      (PROD_W'(total) * PROD_W'(FRAC_NUM));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      light_mask <= '0;
      light_rank <= '0;
    end else begin
      cnt_q <= boundary ? '0 : cnt_q + CNT_W'(1);
      if (boundary) begin
        light_mask <= light_next;
        for (int i = 0; i < N_CORES; i++)
          light_rank[i*CORE_W +: CORE_W] <= rank[i];
      end
    end
  end

endmodule

// File: rtl/cra_shuffler.sv
module cra_shuffler
  import cra_pkg::*;
#(
  parameter int unsigned N_CORES     = 4,
  parameter int unsigned SHUFFLE_CYC = 800,
  parameter logic [15:0] LFSR_SEED   = 16'hACE1,
  localparam int unsigned CORE_W     = idx_w(N_CORES)
) (
  input  logic                       clk,
  input  logic                       rst,
  output logic [N_CORES*CORE_W-1:0]  perm_flat
);

  localparam int unsigned RW    = 16;
  localparam int unsigned PCW   = $clog2(SHUFFLE_CYC + 1);

  logic [CORE_W-1:0] perm_q  [N_CORES];
  logic [CORE_W-1:0] work_q  [N_CORES];
  logic [CORE_W-1:0] work_sw [N_CORES];
  logic [CORE_W-1:0] step_q;
  logic [CORE_W-1:0] pick;
  logic [RW-1:0]     lfsr_q;
  logic [RW-1:0]     span;
  logic [RW-1:0]     pick_full;
  logic [PCW-1:0]    pcnt_q;
  logic              fire;
  logic              fb;
  sh_state_e         st_q;

  assign fire = (pcnt_q == PCW'(SHUFFLE_CYC - 1));
  assign fb   = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

  // One Fisher-Yates step: swap slot step_q with a random slot in [0, step_q].
  always_comb begin
    span      = RW'(step_q) + RW'(1);
    pick_full = lfsr_q % span;
    pick      = pick_full[CORE_W-1:0];
    for (int k = 0; k < N_CORES; k++) work_sw[k] = work_q[k];
    work_sw[step_q] = work_q[pick];
    work_sw[pick]   = work_q[step_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q <= '0;
      st_q   <= SH_IDLE;
      step_q <= '0;
      lfsr_q <= LFSR_SEED;
      for (int k = 0; k < N_CORES; k++) begin
        perm_q[k] <= CORE_W'(k);
        work_q[k] <= CORE_W'(k);
      end
    end else begin
      lfsr_q <= {lfsr_q[RW-2:0], fb};
      pcnt_q <= fire ? '0 : pcnt_q + PCW'(1);
      case (st_q)
        SH_IDLE: begin
          if (fire && (N_CORES > 1)) begin
            for (int k = 0; k < N_CORES; k++) work_q[k] <= perm_q[k];
            step_q <= CORE_W'(N_CORES - 1);
            st_q   <= SH_RUN;
          end
        end
        SH_RUN: begin
          for (int k = 0; k < N_CORES; k++) work_q[k] <= work_sw[k];
          step_q <= step_q - CORE_W'(1);
          if (step_q == CORE_W'(1)) begin
            for (int k = 0; k < N_CORES; k++) perm_q[k] <= work_sw[k];
            st_q <= SH_IDLE;
          end
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end

  for (genvar k = 0; k < N_CORES; k++) begin : g_flat
    assign perm_flat[k*CORE_W +: CORE_W] = perm_q[k];
  end

endmodule

// File: rtl/cra_pick.sv
module cra_pick
  import cra_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned Q_DEPTH = 8,
  parameter int unsigned AGE_W   = 8,
  localparam int unsigned CORE_W = idx_w(N_CORES),
  localparam int unsigned IDX_W  = idx_w(Q_DEPTH)
) (
  input  logic [Q_DEPTH-1:0]         req_valid,
  input  logic [Q_DEPTH*CORE_W-1:0]  req_core,
  input  logic [Q_DEPTH-1:0]         req_row_hit,
  input  logic [Q_DEPTH*AGE_W-1:0]   req_age,
  input  logic [N_CORES-1:0]         light_mask,
  input  logic [N_CORES*CORE_W-1:0]  light_rank,
  input  logic [N_CORES*CORE_W-1:0]  perm_flat,
  output logic                       best_valid,
  output logic [IDX_W-1:0]           best_idx
);

  // key = {valid, light, ~rank, row_hit, age}; larger key wins
  localparam int unsigned KEY_W = 1 + 1 + CORE_W + 1 + AGE_W;

  logic [CORE_W-1:0] pos [N_CORES];
  logic [KEY_W-1:0]  key [Q_DEPTH];
  logic [KEY_W-1:0]  best_key;

  // Position of each core inside the heavy-group permutation.
  always_comb begin
    for (int c = 0; c < N_CORES; c++) begin
      pos[c] = '0;
      for (int k = 0; k < N_CORES; k++)
        if (perm_flat[k*CORE_W +: CORE_W] == CORE_W'(c)) pos[c] = CORE_W'(k);
    end
  end

  for (genvar e = 0; e < Q_DEPTH; e++) begin : g_key
    logic [CORE_W-1:0] core;
    logic              lt;
    logic [CORE_W-1:0] rk;
    assign core = req_core[e*CORE_W +: CORE_W];
    assign lt   = light_mask[core];
    assign rk   = lt ? light_rank[core*CORE_W +: CORE_W] : pos[core];
    assign key[e] = {req_valid[e], lt, ~rk, req_row_hit[e],
                     req_age[e*AGE_W +: AGE_W]};
  end

  // Strictly-greater scan keeps the lowest slot on a full tie.
  always_comb begin
    best_key = '0;
    best_idx = '0;
    for (int e = 0; e < Q_DEPTH; e++) begin
      if (key[e] > best_key) begin
        best_key = key[e];
        best_idx = IDX_W'(e);
      end
    end
    best_valid = best_key[KEY_W-1];
  end

endmodule

// File: rtl/clustered_req_arbiter.sv
module clustered_req_arbiter
  import cra_pkg::*;
#(
  parameter int unsigned N_CORES      = 4,
  parameter int unsigned Q_DEPTH      = 8,
  parameter int unsigned LOAD_W       = 16,
  parameter int unsigned AGE_W        = 8,
  parameter int unsigned INTERVAL_CYC = 10000,
  parameter int unsigned SHUFFLE_CYC  = 800,
  parameter int unsigned FRAC_NUM     = 1,
  parameter int unsigned FRAC_DEN     = 6,
  parameter logic [15:0] LFSR_SEED    = 16'hACE1,
  localparam int unsigned CORE_W      = idx_w(N_CORES),
  localparam int unsigned IDX_W       = idx_w(Q_DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [Q_DEPTH-1:0]          req_valid,
  input  logic [Q_DEPTH*CORE_W-1:0]   req_core,
  input  logic [Q_DEPTH-1:0]          req_row_hit,
  input  logic [Q_DEPTH*AGE_W-1:0]    req_age,
  input  logic [N_CORES*LOAD_W-1:0]   core_load,
  output logic                        grant_valid,
  output logic [IDX_W-1:0]            grant_idx
);

  logic                       boundary;
  logic [N_CORES-1:0]         light_mask;
  logic [N_CORES*CORE_W-1:0]  light_rank;
  logic [N_CORES*CORE_W-1:0]  perm_flat;
  logic                       best_valid;
  logic [IDX_W-1:0]           best_idx;

  cra_cluster_unit #(
    .N_CORES(N_CORES), .LOAD_W(LOAD_W), .INTERVAL_CYC(INTERVAL_CYC),
    .FRAC_NUM(FRAC_NUM), .FRAC_DEN(FRAC_DEN)
  ) u_cluster (
    .clk(clk), .rst(rst), .core_load(core_load),
    .boundary(boundary), .light_mask(light_mask), .light_rank(light_rank)
  );

  cra_shuffler #(
    .N_CORES(N_CORES), .SHUFFLE_CYC(SHUFFLE_CYC), .LFSR_SEED(LFSR_SEED)
  ) u_shuffle (
    .clk(clk), .rst(rst), .perm_flat(perm_flat)
  );

  cra_pick #(
    .N_CORES(N_CORES), .Q_DEPTH(Q_DEPTH), .AGE_W(AGE_W)
  ) u_pick (
    .req_valid(req_valid), .req_core(req_core), .req_row_hit(req_row_hit),
    .req_age(req_age), .light_mask(light_mask), .light_rank(light_rank),
    .perm_flat(perm_flat), .best_valid(best_valid), .best_idx(best_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_idx   <= '0;
    end else begin
      grant_valid <= best_valid;
      if (best_valid) grant_idx <= best_idx;
    end
  end

endmodule

// File: rtl/cra_checker.sv
module cra_checker
  import cra_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned Q_DEPTH = 8,
  localparam int unsigned CORE_W = idx_w(N_CORES),
  localparam int unsigned IDX_W  = idx_w(Q_DEPTH)
) (
  input logic                       clk,
  input logic                       rst,
  input logic [Q_DEPTH-1:0]         req_valid,
  input logic [Q_DEPTH*CORE_W-1:0]  req_core,
  input logic                       grant_valid,
  input logic [IDX_W-1:0]           grant_idx,
  input logic [N_CORES-1:0]         light_mask,
  input logic                       boundary,
  input logic [N_CORES*CORE_W-1:0]  perm_flat
);

  logic [Q_DEPTH-1:0]        vld_q;
  logic [Q_DEPTH*CORE_W-1:0] core_q;
  logic [N_CORES-1:0]        light_q;
  logic                      lp_q;
  logic                      light_pend;
  logic [CORE_W-1:0]         g_core;
  logic [N_CORES-1:0]        seen;

  always_comb begin
    light_pend = 1'b0;
    for (int e = 0; e < Q_DEPTH; e++)
      if (req_valid[e] && light_mask[req_core[e*CORE_W +: CORE_W]]) light_pend = 1'b1;
    seen = '0;
    for (int k = 0; k < N_CORES; k++)
      seen = seen | (N_CORES'(1) << perm_flat[k*CORE_W +: CORE_W]);
    g_core = core_q[grant_idx*CORE_W +: CORE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= '0;
      core_q  <= '0;
      light_q <= '0;
      lp_q    <= 1'b0;
    end else begin
      vld_q   <= req_valid;
      core_q  <= req_core;
      light_q <= light_mask;
      lp_q    <= light_pend;
    end
  end

  // R8
  empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid == '0) |=> (!grant_valid && $stable(grant_idx)));

  // R8
  busy_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid != '0) |=> grant_valid);

  // R7
  grant_pending_chk: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> vld_q[grant_idx]);

  // R1
  light_first_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && lp_q) |-> light_q[g_core]);

  // R9
  cluster_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(light_mask));

  // R4
  perm_legal_chk: assert property (@(posedge clk) disable iff (rst)
    seen == {N_CORES{1'b1}});

endmodule

bind clustered_req_arbiter cra_checker #(
  .N_CORES(N_CORES), .Q_DEPTH(Q_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_core(req_core),
  .grant_valid(grant_valid), .grant_idx(grant_idx),
  .light_mask(light_mask), .boundary(boundary), .perm_flat(perm_flat)
);

// File: tb/clustered_req_arbiter_test.sv
module clustered_req_arbiter_test;

  localparam int CLK_NS   = 10;
  localparam int N        = 4;
  localparam int Q        = 4;
  localparam int LW       = 8;
  localparam int AW       = 4;
  localparam int CW       = 2;
  localparam int IW       = 2;
  localparam int INTERVAL = 32;
  localparam int SHUF     = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [Q-1:0]    req_valid = '0;
  logic [Q*CW-1:0] req_core = '0;
  logic [Q-1:0]    req_row_hit = '0;
  logic [Q*AW-1:0] req_age = '0;
  logic [N*LW-1:0] core_load = '0;
  logic            grant_valid;
  logic [IW-1:0]   grant_idx;

  int total = 0;
  int bad   = 0;
  int unsigned cyc = 0;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  clustered_req_arbiter #(
    .N_CORES(N), .Q_DEPTH(Q), .LOAD_W(LW), .AGE_W(AW),
    .INTERVAL_CYC(INTERVAL), .SHUFFLE_CYC(SHUF), .FRAC_NUM(1), .FRAC_DEN(6)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_core(req_core),
    .req_row_hit(req_row_hit), .req_age(req_age), .core_load(core_load),
    .grant_valid(grant_valid), .grant_idx(grant_idx)
  );

  task automatic set_load(input int a, input int b, input int c, input int d);
    core_load = {LW'(d), LW'(c), LW'(b), LW'(a)};
  endtask

  task automatic clear_reqs();
    req_valid = '0; req_core = '0; req_row_hit = '0; req_age = '0;
  endtask

  task automatic put(input int slot, input int core, input bit hit, input int age);
    req_valid[slot] = 1'b1;
    req_core[slot*CW +: CW] = CW'(core);
    req_row_hit[slot] = hit;
    req_age[slot*AW +: AW] = AW'(age);
  endtask

  task automatic expect_grant(input bit ev, input int ei, input string tag);
    @(negedge clk);
    total++;
    if (grant_valid !== ev || (ev && grant_idx !== IW'(ei))) begin
      bad++;
      $display("FAIL %s: valid=%0b idx=%0d expected valid=%0b idx=%0d",
               tag, grant_valid, grant_idx, ev, ei);
    end
  endtask

  task automatic wait_phase(input int p);
    do @(negedge clk); while ((cyc % INTERVAL) != p);
  endtask

  task automatic t_reset();
    total++;
    if (grant_valid !== 1'b0 || grant_idx !== '0) begin
      bad++;
      $display("FAIL R8 reset: valid=%0b idx=%0d expected valid=0 idx=0", grant_valid, grant_idx);
    end
  endtask

  // loads 2,4,50,60: light {0,1}, heavy {2,3}
  task automatic t_ordering();
    clear_reqs(); put(0, 2, 1, 15); put(1, 1, 0, 0);
    expect_grant(1, 1, "R1 light over heavy");
    clear_reqs(); put(0, 1, 1, 15); put(2, 0, 0, 0);
    expect_grant(1, 2, "R2 lighter core first");
    clear_reqs(); put(0, 1, 0, 9); put(3, 1, 1, 1);
    expect_grant(1, 3, "R5 row hit first");
    clear_reqs(); put(1, 0, 0, 3); put(2, 0, 0, 7);
    expect_grant(1, 2, "R6 older first");
    clear_reqs(); put(1, 0, 1, 5); put(3, 0, 1, 5);
    expect_grant(1, 1, "R7 lowest slot on tie");
    clear_reqs();
    expect_grant(0, 1, "R8 empty holds index");
  endtask

  task automatic t_interval_latch();
    wait_phase(4);
    set_load(100, 4, 50, 1);
    clear_reqs(); put(0, 3, 1, 15); put(1, 0, 0, 0);
    expect_grant(1, 1, "R9 mid-interval load change ignored");
    wait_phase(4);
    clear_reqs(); put(0, 3, 0, 0); put(1, 0, 1, 15);
    expect_grant(1, 0, "R9 new membership after boundary");
  endtask

  task automatic t_membership();
    set_load(1, 1, 1, 100);
    wait_phase(4); wait_phase(4);
    clear_reqs(); put(0, 1, 1, 15); put(3, 0, 0, 0);
    expect_grant(1, 3, "R2 equal load lower core");
    clear_reqs(); put(0, 3, 1, 15); put(1, 2, 0, 0);
    expect_grant(1, 1, "R3 third core light, fourth heavy");
    set_load(0, 0, 0, 0);
    wait_phase(4); wait_phase(4);
    clear_reqs(); put(0, 3, 1, 15); put(1, 2, 0, 0);
    expect_grant(1, 1, "R3 zero total all light");
  endtask

  task automatic t_shuffle();
    int win2 = 0;
    int win3 = 0;
    set_load(2, 4, 50, 60);
    wait_phase(4); wait_phase(4);
    for (int s = 0; s < 30; s++) begin
      clear_reqs(); put(0, 2, 0, 5); put(1, 3, 0, 5);
      @(negedge clk);
      if (grant_valid && grant_idx == 0) win2++;
      else if (grant_valid && grant_idx == 1) win3++;
      repeat (19) @(negedge clk);
    end
    clear_reqs();
    total++;
    if (win2 + win3 != 30) begin
      bad++;
      $display("FAIL R4 heavy pair grants: actual=%0d expected=30", win2 + win3);
    end
    total++;
    if (win2 == 0 || win3 == 0) begin
      bad++;
      $display("FAIL R4 reshuffle: wins core2=%0d core3=%0d expected both nonzero", win2, win3);
    end
  endtask

  initial begin
    set_load(2, 4, 50, 60);
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (40) @(negedge clk);
    wait_phase(4);
    t_ordering();
    t_interval_latch();
    t_membership();
    t_shuffle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule